// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block forms a 32-bit linear address from a segment descriptor and an offset. The caller has already decoded the descriptor into its fields: a 32-bit segment base, a 20-bit size field, a scale bit and a presence bit. It presents them with the offset and pulses a request strobe. One clock later the block returns either the translated address or a fault with a cause code.

The size field has two meanings, chosen by the scale bit. With the bit clear, the field is the highest legal byte offset, so a segment can be at most 1 MB. With the bit set, the field counts 4 KB pages. The highest legal offset then becomes the field shifted up by twelve bits with the low twelve bits filled with ones, which lets a segment span the full 4 GB space.

The block keeps no state between requests other than the result it is holding at its outputs. Each request is judged on its own, so segments may overlap freely. Selector lookup, privilege checks and paging belong to neighbouring logic.

Top module: `seg_xlat`

## Requirements
- R1: `valid_o` is high for exactly the one clock cycle after each cycle in which `req_i` is high, and low otherwise.
- R2: A request with `present_i` = 0 faults with `cause_o` = 2'b01, whatever the offset, size field or scale bit; this cause takes priority over a bounds fault.
- R3: With `gran_i` = 0, a present request faults with `cause_o` = 2'b10 when `offset_i` > `limit_i`; `offset_i` equal to `limit_i` is accepted.
- R4: With `gran_i` = 1, the highest legal offset is `{limit_i, 12'hFFF}`; an offset equal to it is accepted and one greater faults with `cause_o` = 2'b10.
- R5: An accepted request returns `lin_addr_o` = `base_i` + `offset_i` modulo 2^32, with `fault_o` = 0 and `cause_o` = 2'b00.
- R6: A faulting request returns `lin_addr_o` = 0.
- R7: `fault_o` is high exactly when `cause_o` is nonzero, and only in a cycle where `valid_o` is high.
- R8: Between requests, `lin_addr_o` holds the last result and `fault_o`, `cause_o` stay low, even if the descriptor and offset inputs change.
- R9: While reset is asserted, and until the first request after reset, `valid_o`, `fault_o`, `cause_o` and `lin_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Translation request strobe |
| base_i | input | 32 | Segment base address |
| limit_i | input | 20 | Segment size field |
| gran_i | input | 1 | Scale bit: 0 means the size field is in bytes, 1 means it is in 4 KB pages |
| present_i | input | 1 | Segment present bit |
| offset_i | input | 32 | Offset within the segment |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| fault_o | output | 1 | Translation faulted |
| cause_o | output | 2 | Fault cause: 00 none, 01 absent, 10 out of bounds |
| lin_addr_o | output | 32 | Linear address, zero on fault |

## Verification
All result state sits in one register stage, so any wrong internal value shows up at the ports in the cycle right after the request that produced it. A bad scaled limit changes the accept/fault decision only at the boundary offsets. For that reason the stimulus lands exactly on the highest legal offset and one past it, in both scales. A broken priority between absence and bounds shows as cause 10 where 01 is expected, but only when both conditions hold at once. A faulty hold enable shows as an address that changes during idle cycles while the inputs move.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  // Fault cause encoding presented on cause_o.
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_BOUNDS = 2'b10
  } cause_e;

endpackage

// File: rtl/seg_xlat_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on a clock edge.
module seg_xlat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/seg_xlat_bound.sv
// Scales the size field to a byte limit and compares the offset with it.
module seg_xlat_bound #(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               gran_i,
  input  logic [ADDR_W-1:0]  offset_i,
  output logic               over_o
);

  localparam int FINE_PAD   = ADDR_W - LIMIT_W;
  localparam int COARSE_W   = LIMIT_W + PAGE_SHIFT;
  localparam int COARSE_PAD = ADDR_W - COARSE_W;

  logic [ADDR_W-1:0] fine_lim;
  logic [ADDR_W-1:0] coarse_lim;
  logic [ADDR_W-1:0] eff_lim;

  // Byte-scaled limit: the size field as it stands.
  assign fine_lim = {{FINE_PAD{1'b0}}, limit_i};

  // Page-scaled limit: size field moved up, low bits of the page all ones.
  generate
    if (COARSE_PAD > 0) begin : g_coarse_pad
      assign coarse_lim = {{COARSE_PAD{1'b0}}, limit_i, {PAGE_SHIFT{1'b1}}};
    end else begin : g_coarse_full
      assign coarse_lim = {limit_i, {PAGE_SHIFT{1'b1}}};
    end
  endgenerate

  always_comb begin
    eff_lim = gran_i ? coarse_lim : fine_lim;
    over_o  = (offset_i > eff_lim);
  end

endmodule

// File: rtl/seg_xlat_sum.sv
// Base plus offset, wrapping at the address width.
module seg_xlat_sum #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] offset_i,
  output logic [ADDR_W-1:0] sum_o
);

  logic [ADDR_W:0] full_sum;

  always_comb begin
    full_sum = {1'b0, base_i} + {1'b0, offset_i};
    sum_o    = full_sum[ADDR_W-1:0];
  end

endmodule

// File: rtl/seg_xlat.sv
// Descriptor + offset to linear address, with presence and bounds faults.
module seg_xlat #(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int SYNC_STG   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               gran_i,
  input  logic               present_i,
  input  logic [ADDR_W-1:0]  offset_i,
  output logic               valid_o,
  output logic               fault_o,
  output logic [1:0]         cause_o,
  output logic [ADDR_W-1:0]  lin_addr_o
);

  import seg_xlat_pkg::*;

  logic              rst_sync_n;
  logic              over;
  logic [ADDR_W-1:0] sum;

  cause_e            cause_calc;
  logic              valid_d, valid_q;
  logic              fault_d, fault_q;
  cause_e            cause_d, cause_q;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_d, addr_q;

  seg_xlat_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_xlat_bound #(
    .ADDR_W     (ADDR_W),
    .LIMIT_W    (LIMIT_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_bound (
    .limit_i  (limit_i),
    .gran_i   (gran_i),
    .offset_i (offset_i),
    .over_o   (over)
  );

  seg_xlat_sum #(.ADDR_W(ADDR_W)) u_sum (
    .base_i   (base_i),
    .offset_i (offset_i),
    .sum_o    (sum)
  );

  // Next-state logic. Absence outranks the bounds check.
  always_comb begin
    if (!present_i) begin
      cause_calc = CAUSE_ABSENT;
    end else if (over) begin
      cause_calc = CAUSE_BOUNDS;
    end else begin
      cause_calc = CAUSE_NONE;
    end

    valid_d = req_i;
    fault_d = req_i && (cause_calc != CAUSE_NONE);
    cause_d = req_i ? cause_calc : CAUSE_NONE;
    addr_en = req_i;
    addr_d  = (cause_calc == CAUSE_NONE) ? sum : '0;
  end

  // Strobe and status registers: updated every cycle.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end

  // Address register: loaded only on a request, held otherwise.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign valid_o    = valid_q;
  assign fault_o    = fault_q;
  assign cause_o    = cause_q;
  assign lin_addr_o = addr_q;

endmodule

// File: rtl/seg_xlat_chk.sv
// Port-level properties of the translator, bound into every instance.
module seg_xlat_chk #(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_i,
  input logic [ADDR_W-1:0]  base_i,
  input logic [LIMIT_W-1:0] limit_i,
  input logic               gran_i,
  input logic               present_i,
  input logic [ADDR_W-1:0]  offset_i,
  input logic               valid_o,
  input logic               fault_o,
  input logic [1:0]         cause_o,
  input logic [ADDR_W-1:0]  lin_addr_o
);

  // Set once one clock has passed out of reset, so $past is meaningful.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (valid_o == $past(req_i)));  // R1

  AST_ABSENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_i && !present_i)) |-> (cause_o == 2'b01));  // R2

  AST_FINE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_i && present_i && !gran_i &&
                      (offset_i <= ADDR_W'(limit_i))))
      |-> (!fault_o && lin_addr_o == ($past(base_i) + $past(offset_i))));  // R5

  AST_ZERO_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (lin_addr_o == '0));  // R6

  AST_FAULT_MATCHES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o == (cause_o != 2'b00));  // R7

  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> valid_o);  // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(req_i)) |-> $stable(lin_addr_o));  // R8

endmodule

bind seg_xlat seg_xlat_chk #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_i      (req_i),
  .base_i     (base_i),
  .limit_i    (limit_i),
  .gran_i     (gran_i),
  .present_i  (present_i),
  .offset_i   (offset_i),
  .valid_o    (valid_o),
  .fault_o    (fault_o),
  .cause_o    (cause_o),
  .lin_addr_o (lin_addr_o)
);

// File: tb/seg_xlat_test.sv
module seg_xlat_test;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] lim;
    logic        gran;
    logic        pres;
    logic [31:0] off;
    logic [1:0]  cause;
    logic [31:0] addr;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000_0000, 20'h00FFF, 1'b0, 1'b1, 32'h0000_0FFF, 2'b00, 32'h1000_0FFF}, // R3 edge ok
    '{32'h1000_0000, 20'h00FFF, 1'b0, 1'b1, 32'h0000_1000, 2'b10, 32'h0000_0000}, // R3 one past
    '{32'h0040_0000, 20'h00003, 1'b1, 1'b1, 32'h0000_3FFF, 2'b00, 32'h0040_3FFF}, // R4 edge ok
    '{32'h0040_0000, 20'h00003, 1'b1, 1'b1, 32'h0000_4000, 2'b10, 32'h0000_0000}, // R4 one past
    '{32'h2000_0000, 20'h00FFF, 1'b0, 1'b0, 32'h0000_0000, 2'b01, 32'h0000_0000}, // R2
    '{32'h2000_0000, 20'h00001, 1'b0, 1'b0, 32'h0000_9000, 2'b01, 32'h0000_0000}, // R2 priority
    '{32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 32'h0000_2000, 2'b00, 32'h0000_1000}, // R5 wrap
    '{32'h0000_0010, 20'hFFFFF, 1'b1, 1'b1, 32'hFFFF_FFFF, 2'b00, 32'h0000_000F}, // R4 full span
    '{32'h0000_0000, 20'hFFFFF, 1'b0, 1'b1, 32'h000F_FFFF, 2'b00, 32'h000F_FFFF}, // R3 1 MB edge
    '{32'h0000_0000, 20'hFFFFF, 1'b0, 1'b1, 32'h0010_0000, 2'b10, 32'h0000_0000}, // R3 past 1 MB
    '{32'h1000_0800, 20'h00FFF, 1'b0, 1'b1, 32'h0000_07FF, 2'b00, 32'h1000_0FFF}, // R5 overlap
    '{32'h1234_5678, 20'h00000, 1'b0, 1'b1, 32'h0000_0000, 2'b00, 32'h1234_5678}  // R3 zero size
  };

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [31:0] base_i;
  logic [19:0] limit_i;
  logic        gran_i;
  logic        present_i;
  logic [31:0] offset_i;
  logic        valid_o;
  logic        fault_o;
  logic [1:0]  cause_o;
  logic [31:0] lin_addr_o;

  int checks;
  int failures;

  seg_xlat uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .base_i     (base_i),
    .limit_i    (limit_i),
    .gran_i     (gran_i),
    .present_i  (present_i),
    .offset_i   (offset_i),
    .valid_o    (valid_o),
    .fault_o    (fault_o),
    .cause_o    (cause_o),
    .lin_addr_o (lin_addr_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic rq);
    base_i    = v.base;
    limit_i   = v.lim;
    gran_i    = v.gran;
    present_i = v.pres;
    offset_i  = v.off;
    req_i     = rq;
  endtask

  // Compare outputs with a vector's expected result (called at a negedge).
  task automatic check_result(vec_t v);
    string tag;
    string atag;
    if (v.cause == 2'b01)      tag = "R2";
    else if (v.cause == 2'b10) tag = v.gran ? "R4" : "R3";
    else                       tag = "R5";
    atag = (v.cause != 2'b00) ? "R6" : "R5";
    check("R1", "valid", 32'(valid_o), 32'd1);
    check(tag, "cause", 32'(cause_o), 32'(v.cause));
    check("R7", "fault", 32'(fault_o), 32'(v.cause != 2'b00));
    check(atag, "addr", lin_addr_o, v.addr);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t idle_v;
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    idle_v   = '{32'hDEAD_0000, 20'h00010, 1'b1, 1'b1, 32'h0000_0004, 2'b00, 32'h0};
    drive(idle_v, 1'b0);

    // R9: outputs cleared during reset.
    repeat (3) @(negedge clk);
    check("R9", "valid in reset", 32'(valid_o), 32'd0);
    check("R9", "fault in reset", 32'(fault_o), 32'd0);
    check("R9", "cause in reset", 32'(cause_o), 32'd0);
    check("R9", "addr in reset", lin_addr_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", "valid after reset", 32'(valid_o), 32'd0);
    check("R9", "addr after reset", lin_addr_o, 32'd0);

    // Table walk: one isolated request per vector.
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      req_i = 1'b0;
      check_result(VECS[i]);
      @(negedge clk);
      check("R1", "valid drops", 32'(valid_o), 32'd0);
    end

    // R8: hold the last good address while inputs churn without a request.
    drive(VECS[0], 1'b1);
    @(negedge clk);
    drive(VECS[6], 1'b0);
    @(negedge clk);
    drive(VECS[3], 1'b0);
    @(negedge clk);
    drive(VECS[4], 1'b0);
    @(negedge clk);
    check("R8", "addr held", lin_addr_o, VECS[0].addr);
    check("R8", "fault idle", 32'(fault_o), 32'd0);
    check("R8", "cause idle", 32'(cause_o), 32'd0);
    check("R1", "valid idle", 32'(valid_o), 32'd0);

    // R1: back-to-back requests, fault then success then fault.
    drive(VECS[1], 1'b1);
    @(negedge clk);
    check_result(VECS[1]);
    drive(VECS[7], 1'b1);
    @(negedge clk);
    check_result(VECS[7]);
    drive(VECS[5], 1'b1);
    @(negedge clk);
    check_result(VECS[5]);
    drive(VECS[8], 1'b0);
    @(negedge clk);
    check("R1", "valid after burst", 32'(valid_o), 32'd0);
    check("R8", "zero held after fault", lin_addr_o, 32'd0);

    // R9: a mid-run reset clears a held address.
    drive(VECS[11], 1'b1);
    @(negedge clk);
    req_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "addr cleared by reset", lin_addr_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", "valid after second reset", 32'(valid_o), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule